// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is one output cell of a small programmable logic array. It takes the sum term that the array has built for this cell and shapes it into a pin drive. The sum can pass straight through or be held in a D flip-flop. The result is driven active-high or active-low. The cell also sends one feedback bit back into the array, taken from the pin, the flip-flop or the raw sum.

A four-bit mode word chooses output path, polarity and feedback source. Twelve encodings are defined, and the remaining four fall back to a safe combinational setting. The flip-flop captures on a rising edge of a chosen capture clock. That clock is the dedicated clock pin or a clock product term, in true or inverted form.

Edges of the capture clock are found by sampling it with the system clock `clk`, so the whole cell lives in one clock domain. A preset term loads a one at the next capture edge. A clear term forces the stored bit to zero at once, and clear wins over preset. The pad is modelled as separate input, output and enable ports.

Top module: `macrocell_unit`

## Requirements
- R1: Mode bit 2 picks the output path: 0 drives the stored flip-flop bit, 1 drives the sum term combinationally.
- R2: Mode bit 3 sets polarity: 1 drives the selected value unchanged, 0 drives its inverse.
- R3: Mode bit 0 set to 1 (with bit 1 also 1) feeds the sum term back. With bit 0 clear, feedback is `pin_in` when bit 2 differs from bit 1, and the true stored bit when they are equal. Feedback does not depend on the drive enable or the output path.
- R4: Mode words with bit 0 = 1 and bit 1 = 0 (values 1, 5, 9, 13) drive the sum combinationally and feed back `pin_in`, with polarity still from bit 3.
- R5: The stored bit changes only at a rising edge of the selected capture clock. A level held high or a falling edge leaves it unchanged.
- R6: `clk_from_term` = 0 selects `clk_pin` and 1 selects `clk_term`. `clk_invert` = 1 makes a falling edge of that source the capture edge.
- R7: With `preset_term` high at a capture edge, the stored bit becomes 1 whatever the sum term.
- R8: `clear_term` high forces the stored bit to 0 in the same cycle, with no capture edge, and holds it there. Clear overrides a preset at the same capture edge.
- R9: `pin_oe` follows `oe_term` in every mode.
- R10: `rst` high at a rising edge of `clk` clears the stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the capture clocks |
| rst | input | 1 | Synchronous active-high reset |
| sum_term | input | 1 | OR sum from the array for this cell |
| oe_term | input | 1 | Output enable product term |
| preset_term | input | 1 | Synchronous preset term |
| clear_term | input | 1 | Immediate clear term |
| clk_pin | input | 1 | Dedicated capture clock pin |
| clk_term | input | 1 | Capture clock product term |
| clk_from_term | input | 1 | Capture clock source: 0 pin, 1 term |
| clk_invert | input | 1 | Capture on falling edge of source when 1 |
| mode_word | input | 4 | Bit 3 polarity, bit 2 path, bit 1 alternate, bit 0 sum feedback |
| pin_in | input | 1 | Level seen at the pad |
| pin_out | output | 1 | Value driven to the pad |
| pin_oe | output | 1 | Pad drive enable |
| fb_out | output | 1 | Feedback bit returned to the array |

## Verification
Combinational results have no latency. These are the pin drive in sum mode, the feedback bit, the drive enable and the effect of clear on the stored bit. The bench checks them 1 ns after changing inputs at a falling edge of `clk`, before any rising edge. A capture happens at the first rising edge of `clk` that sees the selected source at its active level after a cycle at the other level. So every capture stimulus holds each level for a full cycle, and the stored result is read at the next falling edge. Cases that must not capture are read after several further cycles, so that a late capture would also show.

// File: rtl/macrocell_pkg.sv
package macrocell_pkg;

    localparam int MODE_W   = 4;
    localparam int BIT_POL  = 3;
    localparam int BIT_PATH = 2;
    localparam int BIT_ALT  = 1;
    localparam int BIT_SUMF = 0;

    typedef enum logic [1:0] {
        FB_FROM_PIN = 2'd0,
        FB_FROM_REG = 2'd1,
        FB_FROM_SUM = 2'd2
    } fb_src_e;

    typedef enum logic {
        PATH_REG  = 1'b0,
        PATH_COMB = 1'b1
    } out_path_e;

    typedef enum logic {
        CLKSRC_PIN  = 1'b0,
        CLKSRC_TERM = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic      act_high;
        out_path_e path;
        fb_src_e   fb;
    } cell_cfg_t;

    function automatic cell_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        cell_cfg_t c;
        logic      defined;
        defined    = !(m[BIT_SUMF] && !m[BIT_ALT]);
        c.act_high = m[BIT_POL];
        if (!defined) begin
            c.path = PATH_COMB;
            c.fb   = FB_FROM_PIN;
        end else begin
            c.path = m[BIT_PATH] ? PATH_COMB : PATH_REG;
            if (m[BIT_SUMF])
                c.fb = FB_FROM_SUM;
            else if (m[BIT_PATH] != m[BIT_ALT])
                c.fb = FB_FROM_PIN;
            else
                c.fb = FB_FROM_REG;
        end
        return c;
    endfunction

    function automatic logic apply_pol(input logic v, input logic act_high);
        return act_high ? v : ~v;
    endfunction

endpackage

// File: rtl/mc_mode_decode.sv
module mc_mode_decode
    import macrocell_pkg::*;
(
    input  logic [MODE_W-1:0] mode_word,
    output cell_cfg_t         cfg
);

    always_comb begin
        cfg = decode_mode(mode_word);
    end

endmodule

// File: rtl/mc_clk_edge.sv
module mc_clk_edge
    import macrocell_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_pin,
    input  logic     clk_term,
    input  clk_src_e src,
    input  logic     invert,
    output logic     cap_en
);

    logic src_lvl;
    logic sel_lvl;
    logic prev_lvl;

    always_comb begin
        src_lvl = (src == CLKSRC_TERM) ? clk_term : clk_pin;
        sel_lvl = src_lvl ^ invert;
        cap_en  = sel_lvl & ~prev_lvl & ~rst;
    end

    always_ff @(posedge clk) begin
        if (rst)
            prev_lvl <= 1'b1;
        else
            prev_lvl <= sel_lvl;
    end

    // R5
    cap_single_chk: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> !cap_en);

endmodule

// File: rtl/mc_flop.sv
module mc_flop
    import macrocell_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  logic d_in,
    input  logic preset_term,
    input  logic clear_term,
    output logic q_eff
);

    logic q_reg;

    always_ff @(posedge clk) begin
        if (rst || clear_term)
            q_reg <= 1'b0;
        else if (cap_en)
            q_reg <= preset_term ? 1'b1 : d_in;
    end

    always_comb begin
        q_eff = q_reg & ~clear_term;
    end

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clear_term |=> (q_reg == 1'b0));

    // R7
    preset_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (cap_en && preset_term && !clear_term) |=> q_reg);

    // R5
    hold_no_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !clear_term) |=> $stable(q_reg));

endmodule

// File: rtl/mc_out_stage.sv
module mc_out_stage
    import macrocell_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      sum_term,
    input  logic      q_eff,
    input  logic      pin_in,
    input  logic      oe_term,
    output logic      pin_out,
    output logic      pin_oe,
    output logic      fb_out
);

    logic path_val;

    always_comb begin
        path_val = (cfg.path == PATH_COMB) ? sum_term : q_eff;
        pin_out  = apply_pol(path_val, cfg.act_high);
        pin_oe   = oe_term;
        unique case (cfg.fb)
            FB_FROM_SUM: fb_out = sum_term;
            FB_FROM_REG: fb_out = q_eff;
            default:     fb_out = pin_in;
        endcase
    end

endmodule

// File: rtl/macrocell_unit.sv
module macrocell_unit
    import macrocell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sum_term,
    input  logic              oe_term,
    input  logic              preset_term,
    input  logic              clear_term,
    input  logic              clk_pin,
    input  logic              clk_term,
    input  logic              clk_from_term,
    input  logic              clk_invert,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              fb_out
);

    cell_cfg_t cfg;
    clk_src_e  src;
    logic      cap_en;
    logic      q_eff;

    always_comb begin
        src = clk_from_term ? CLKSRC_TERM : CLKSRC_PIN;
    end

    mc_mode_decode u_decode (
        .mode_word (mode_word),
        .cfg       (cfg)
    );

    mc_clk_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .clk_pin  (clk_pin),
        .clk_term (clk_term),
        .src      (src),
        .invert   (clk_invert),
        .cap_en   (cap_en)
    );

    mc_flop u_flop (
        .clk         (clk),
        .rst         (rst),
        .cap_en      (cap_en),
        .d_in        (sum_term),
        .preset_term (preset_term),
        .clear_term  (clear_term),
        .q_eff       (q_eff)
    );

    mc_out_stage u_out (
        .cfg      (cfg),
        .sum_term (sum_term),
        .q_eff    (q_eff),
        .pin_in   (pin_in),
        .oe_term  (oe_term),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .fb_out   (fb_out)
    );

    // R8
    clear_zero_fb_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_term && mode_word == 4'b1000) |-> (pin_out == 1'b0 && fb_out == 1'b0));

endmodule

// File: tb/macrocell_unit_bench.sv
module macrocell_unit_bench;

    typedef struct packed {
        logic [3:0] mode;
        logic       oe;
        logic       qv;
        logic       ov;
        logic       pv;
        logic       exp_out;
        logic       exp_fb;
    } vec_t;

    // mode, oe, stored value, sum, pin, expected out, expected feedback
    localparam vec_t VECS [16] = '{
        '{4'h2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'hA, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'h4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'hC, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'h3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'hB, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{4'h7, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
        '{4'hF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{4'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'h8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'h6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
        '{4'hE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        '{4'h1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'h9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        '{4'h5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{4'hD, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sum_term = 1'b0;
    logic       oe_term = 1'b0;
    logic       preset_term = 1'b0;
    logic       clear_term = 1'b0;
    logic       clk_pin = 1'b0;
    logic       clk_term = 1'b0;
    logic       clk_from_term = 1'b0;
    logic       clk_invert = 1'b0;
    logic [3:0] mode_word = 4'h0;
    logic       pin_in = 1'b0;
    logic       pin_out;
    logic       pin_oe;
    logic       fb_out;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    macrocell_unit u_macrocell_unit (
        .clk           (clk),
        .rst           (rst),
        .sum_term      (sum_term),
        .oe_term       (oe_term),
        .preset_term   (preset_term),
        .clear_term    (clear_term),
        .clk_pin       (clk_pin),
        .clk_term      (clk_term),
        .clk_from_term (clk_from_term),
        .clk_invert    (clk_invert),
        .mode_word     (mode_word),
        .pin_in        (pin_in),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe),
        .fb_out        (fb_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pin_rise();
        clk_pin = 1'b0;
        tick();
        clk_pin = 1'b1;
        tick();
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        rst = 1'b0;
        // R10: stored bit zero after reset; mode 0 is registered, active-low, stored-bit feedback
        mode_word = 4'h0;
        #1;
        check("R10 out after reset", pin_out, 1'b1);
        check("R10 fb after reset", fb_out, 1'b0);
        tick();

        // R1 R2 R3 R4 R9: every mode word
        for (int i = 0; i < 16; i++) begin
            mode_word = VECS[i].mode;
            oe_term   = VECS[i].oe;
            pin_in    = VECS[i].pv;
            sum_term  = VECS[i].qv;
            pin_rise();
            sum_term  = VECS[i].ov;
            #1;
            check("R1 R2 pin_out", pin_out, VECS[i].exp_out);
            if (VECS[i].mode[1:0] == 2'b01)
                check("R4 fb_out", fb_out, VECS[i].exp_fb);
            else
                check("R3 fb_out", fb_out, VECS[i].exp_fb);
            check("R9 pin_oe", pin_oe, VECS[i].oe);
            tick();
        end

        // R7: preset loads one despite sum low; mode 8 registered, active-high, stored-bit feedback
        mode_word = 4'h8;
        oe_term = 1'b1;
        sum_term = 1'b0;
        pin_rise();
        check("R7 setup cleared", pin_out, 1'b0);
        preset_term = 1'b1;
        pin_rise();
        preset_term = 1'b0;
        check("R7 preset out", pin_out, 1'b1);
        check("R7 preset fb", fb_out, 1'b1);

        // R8: clear acts before any clock edge
        clear_term = 1'b1;
        #1;
        check("R8 immediate clear out", pin_out, 1'b0);
        check("R8 immediate clear fb", fb_out, 1'b0);
        tick();
        // R8: clear overrides preset at a capture edge
        preset_term = 1'b1;
        pin_rise();
        clear_term = 1'b0;
        #1;
        check("R8 clear beats preset", pin_out, 1'b0);
        preset_term = 1'b0;
        tick();

        // R5: high level and falling edge do not capture
        sum_term = 1'b1;
        tick();
        tick();
        tick();
        check("R5 held high no capture", pin_out, 1'b0);
        clk_pin = 1'b0;
        tick();
        tick();
        check("R5 falling no capture", pin_out, 1'b0);
        clk_pin = 1'b1;
        tick();
        check("R5 rising captures", pin_out, 1'b1);

        // R6: inverted pin source captures on falling edge only
        clk_invert = 1'b1;
        tick();
        tick();
        sum_term = 1'b0;
        clk_pin = 1'b0;
        tick();
        check("R6 inverted falling captures", pin_out, 1'b0);
        sum_term = 1'b1;
        clk_pin = 1'b1;
        tick();
        tick();
        check("R6 inverted rising ignored", pin_out, 1'b0);

        // R6: term source ignores the pin
        clk_invert = 1'b0;
        clk_from_term = 1'b1;
        clk_term = 1'b0;
        tick();
        tick();
        clk_pin = 1'b0;
        tick();
        clk_pin = 1'b1;
        tick();
        check("R6 term source ignores pin", pin_out, 1'b0);
        clk_term = 1'b1;
        tick();
        check("R6 term source captures", pin_out, 1'b1);

        // R10: reset mid-run clears stored bit
        rst = 1'b1;
        tick();
        rst = 1'b0;
        #1;
        check("R10 reset mid-run", pin_out, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule